// File: doc/BRIEF.md
# SD Command Token Builder and Serializer

This block turns a 6-bit command index and a 32-bit argument into the 48-bit token that an SD host places on the CMD line. The token starts with a framing byte that holds a 0 start bit, a 1 transmission bit and the index. Four argument bytes follow, most significant byte first. The last byte holds a seven-bit CRC followed by a 1 end bit.

A single-cycle `start` pulse latches the index and argument. The block then computes the CRC one bit per system clock over the first 40 token bits. Once the CRC is known, it loads the whole token into three 16-bit word outputs and into a shift stage. The shift stage drives CMD MSB-first, with each bit held for `BIT_DIV` system clocks, which form one card-clock period. `busy` covers the whole operation. `done` pulses once when the end bit has finished. The word outputs keep the most recent token until the next one is loaded, so software-style logic can read it back in register order.

Top module: `sd_cmd_token_tx`

## Requirements
- R1: The high byte of `word_hi` (bits 15:8) equals 0x40 OR the command index, so token bit 47 is 0 and bit 46 is 1.
- R2: The argument occupies the token most significant byte first: `word_hi[7:0]` = arg[31:24], `word_mid` = arg[23:8] and `word_lo[15:8]` = arg[7:0].
- R3: `word_lo[7:1]` holds the CRC7 (polynomial x^7 + x^3 + 1, initial value zero, fed MSB-first) of token bits 47..8, and `word_lo[0]` is 1.
- R4: `cmd_out` carries the 48-bit token {word_hi, word_mid, word_lo} MSB-first, with each bit held for exactly `BIT_DIV` clock cycles.
- R5: `cmd_out` is 1 whenever no token is being shifted out, including during reset and during the CRC phase.
- R6: `busy` rises in the cycle after a `start` is accepted while idle, and it stays high until the cycle in which `done` pulses.
- R7: A `start` seen while `busy` is high is ignored. The token in flight and the word outputs still match the first request, and no second transfer follows.
- R8: `done` is high for exactly one cycle, `BIT_DIV` cycles after the end bit first appears on `cmd_out`. `busy` falls in that same cycle.
- R9: After reset, `busy` and `done` are 0, `cmd_out` is 1 and all three word outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; accepted only while idle |
| cmd_index | input | 6 | Command index sampled at start |
| cmd_arg | input | 32 | Command argument sampled at start |
| busy | output | 1 | High from acceptance until done |
| done | output | 1 | One-cycle pulse after the end bit |
| word_hi | output | 16 | Token bits 47..32 (framing byte, arg MSB) |
| word_mid | output | 16 | Token bits 31..16 (arg bits 23..8) |
| word_lo | output | 16 | Token bits 15..0 (arg LSB, CRC, end bit) |
| cmd_out | output | 1 | Serial CMD line, idle high |

## Verification
Two directed tokens whose CRC bytes are known constants (index 0 with a zero argument gives 0x95, and index 8 with argument 0x1AA gives 0x87) pin the polynomial and the bit order independently of any model. An all-ones index and argument, together with a single-bit argument pattern, separate the byte lanes and expose any swap of word order or byte order. Random indices and arguments from a fixed seed, checked against a bench model, cover the wide CRC space. Some of these transfers are given a second start with inverted fields during the CRC phase, which separates an ignored request from one that corrupts the token or queues a second transfer.

// File: rtl/sd_tok_pkg.sv
// Package: shared widths, state type and the token body helper for the
// SD command token builder. Assumes a 6-bit index and a 32-bit argument.
package sd_tok_pkg;
    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int CRC_W   = 7;
    localparam int BODY_W  = 2 + IDX_W + ARG_W;   // 40 bits covered by CRC
    localparam int TOKEN_W = BODY_W + CRC_W + 1;  // 48 bits on the wire
    localparam int WORD_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CRC  = 2'd1,
        ST_LOAD = 2'd2,
        ST_SEND = 2'd3
    } tok_state_e;

    // Build the 40-bit body: start bit 0, transmission bit 1, index, argument.
    function automatic logic [BODY_W-1:0] make_body(input logic [IDX_W-1:0] idx,
                                                    input logic [ARG_W-1:0] arg);
        return {2'b01, idx, arg};
    endfunction
endpackage

// File: rtl/sd_tok_crc7.sv
// Bit-serial CRC engine. One input bit per enabled cycle, MSB-first.
// Assumes the caller clears it before the first bit of a new message.
module sd_tok_crc7 #(
    parameter int           CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY = 7'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic feedback;

    // Feedback term: incoming bit against the register MSB.
    always_comb feedback = din ^ crc[CRC_W-1];

    // CRC register update: shift left and fold in the polynomial on feedback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= '0;
        else if (clear)
            crc <= '0;
        else if (en)
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end
endmodule

// File: rtl/sd_tok_framer.sv
// Combinational framer: joins body and CRC into the token and splits it
// into register words, most significant word first. Assumes TOKEN_W is a
// multiple of WORD_W.
module sd_tok_framer #(
    parameter int BODY_W  = 40,
    parameter int CRC_W   = 7,
    parameter int WORD_W  = 16,
    localparam int TOKEN_W = BODY_W + CRC_W + 1,
    localparam int N_WORDS = TOKEN_W / WORD_W
) (
    input  logic [BODY_W-1:0]          body,
    input  logic [CRC_W-1:0]           crc,
    output logic [TOKEN_W-1:0]         token,
    output logic [N_WORDS*WORD_W-1:0]  words
);
    // Token assembly: body, CRC, then the end bit.
    always_comb token = {body, crc, 1'b1};

    // Word slicing: word N_WORDS-1 carries the first wire bits.
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        assign words[w*WORD_W +: WORD_W] = token[w*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/sd_tok_shifter.sv
// Serial output stage: loads a token and shifts it out MSB-first, one bit
// every DIV clocks. The line rests high when not shifting. Assumes load is
// only asserted while the stage is idle.
module sd_tok_shifter #(
    parameter int TOKEN_W = 48,
    parameter int DIV     = 4,
    localparam int DIV_W  = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int BIT_W  = $clog2(TOKEN_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TOKEN_W-1:0] token_in,
    output logic               ser_out,
    output logic               finish
);
    logic [TOKEN_W-1:0] sreg;
    logic [DIV_W-1:0]   div_cnt;
    logic [BIT_W-1:0]   bit_cnt;
    logic               active;
    logic               tick;

    // Bit period tick: every cycle when DIV is 1, else at the counter limit.
    if (DIV == 1) begin : g_nodiv
        assign tick = 1'b1;
    end else begin : g_div
        assign tick = (div_cnt == DIV_W'(DIV - 1));
    end

    // Final tick of the last token bit.
    always_comb finish = active && tick && (bit_cnt == BIT_W'(TOKEN_W - 1));

    // Line drive: token MSB while active, idle high otherwise.
    always_comb ser_out = active ? sreg[TOKEN_W-1] : 1'b1;

    // Shift register, bit period counter and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '1;
            div_cnt <= '0;
            bit_cnt <= '0;
            active  <= 1'b0;
        end else if (load) begin
            sreg    <= token_in;
            div_cnt <= '0;
            bit_cnt <= '0;
            active  <= 1'b1;
        end else if (active) begin
            if (tick) begin
                div_cnt <= '0;
                sreg    <= {sreg[TOKEN_W-2:0], 1'b1};
                bit_cnt <= bit_cnt + 1'b1;
                if (finish)
                    active <= 1'b0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sd_cmd_token_tx.sv
// SD command token builder and CMD-line serializer. Latches index and
// argument on an idle start, computes CRC7 bit-serially over the 40 body
// bits, publishes the token as three words and shifts it out. Assumes
// start is a synchronous level sampled each cycle; starts while busy drop.
module sd_cmd_token_tx #(
    parameter int BIT_DIV = 4,
    localparam int IDX_W   = sd_tok_pkg::IDX_W,
    localparam int ARG_W   = sd_tok_pkg::ARG_W,
    localparam int WORD_W  = sd_tok_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] word_hi,
    output logic [WORD_W-1:0] word_mid,
    output logic [WORD_W-1:0] word_lo,
    output logic              cmd_out
);
    import sd_tok_pkg::*;

    localparam int N_WORDS = TOKEN_W / WORD_W;
    localparam int CNT_W   = $clog2(BODY_W);

    tok_state_e                state;
    logic [BODY_W-1:0]         body_q;
    logic [BODY_W-1:0]         crc_feed;
    logic [CNT_W-1:0]          crc_cnt;
    logic [CRC_W-1:0]          crc_val;
    logic [TOKEN_W-1:0]        token;
    logic [N_WORDS*WORD_W-1:0] words_new;
    logic [N_WORDS*WORD_W-1:0] words_q;
    logic                      accept;
    logic                      finish;
    logic                      done_q;

    // Request acceptance: only from idle.
    always_comb accept = start && (state == ST_IDLE);

    sd_tok_crc7 #(
        .CRC_W (CRC_W),
        .POLY  (7'h09)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (state == ST_CRC),
        .din   (crc_feed[BODY_W-1]),
        .crc   (crc_val)
    );

    sd_tok_framer #(
        .BODY_W (BODY_W),
        .CRC_W  (CRC_W),
        .WORD_W (WORD_W)
    ) u_framer (
        .body  (body_q),
        .crc   (crc_val),
        .token (token),
        .words (words_new)
    );

    sd_tok_shifter #(
        .TOKEN_W (TOKEN_W),
        .DIV     (BIT_DIV)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_LOAD),
        .token_in (token),
        .ser_out  (cmd_out),
        .finish   (finish)
    );

    // Sequencer: idle, CRC over the body, load, then send until finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            body_q   <= '0;
            crc_feed <= '0;
            crc_cnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    body_q   <= make_body(cmd_index, cmd_arg);
                    crc_feed <= make_body(cmd_index, cmd_arg);
                    crc_cnt  <= '0;
                    state    <= ST_CRC;
                end
                ST_CRC: begin
                    crc_feed <= {crc_feed[BODY_W-2:0], 1'b0};
                    crc_cnt  <= crc_cnt + 1'b1;
                    if (crc_cnt == CNT_W'(BODY_W - 1))
                        state <= ST_LOAD;
                end
                ST_LOAD: state <= ST_SEND;
                ST_SEND: if (finish) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Word register: captures the finished token at load time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            words_q <= '0;
        else if (state == ST_LOAD)
            words_q <= words_new;
    end

    // Completion pulse: registered copy of the shifter's last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= finish;
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign word_hi  = words_q[2*WORD_W +: WORD_W];
    assign word_mid = words_q[1*WORD_W +: WORD_W];
    assign word_lo  = words_q[0*WORD_W +: WORD_W];
endmodule

// File: rtl/sd_cmd_token_tx_chk.sv
// Checker for sd_cmd_token_tx, attached by bind. Observes ports only.
module sd_cmd_token_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [15:0] word_hi,
    input logic [15:0] word_lo,
    input logic        cmd_out
);
    // Line rests high outside a transfer.
    assert_cmd_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cmd_out);

    // An idle start raises busy next cycle.
    assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // Busy only falls together with done.
    assert_busy_fall_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // Done is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done closes a transfer: busy low now.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // Published framing bits at completion.
    assert_frame_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word_hi[15:14] == 2'b01));

    // Published end bit at completion.
    assert_end_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> word_lo[0]);
endmodule

bind sd_cmd_token_tx sd_cmd_token_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .word_hi (word_hi),
    .word_lo (word_lo),
    .cmd_out (cmd_out)
);

// File: tb/sd_cmd_token_tx_bench.sv
`timescale 1ns/1ps
// Bench: directed and seeded random tokens, checked at the ports.
module sd_cmd_token_tx_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        busy, done, cmd_out;
    logic [15:0] word_hi, word_mid, word_lo;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sd_cmd_token_tx #(.BIT_DIV(DIV)) u_sd_cmd_token_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_index (cmd_index),
        .cmd_arg   (cmd_arg),
        .busy      (busy),
        .done      (done),
        .word_hi   (word_hi),
        .word_mid  (word_mid),
        .word_lo   (word_lo),
        .cmd_out   (cmd_out)
    );

    // Reference CRC7, x^7 + x^3 + 1, zero start, MSB-first over 40 bits.
    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            if (m[i] ^ c[6]) c = {c[5:0], 1'b0} ^ 7'h09;
            else             c = {c[5:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [47:0] ref_token(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] m = {8'h40 | {2'b00, idx}, arg};
        return {m, ref_crc(m), 1'b1};
    endfunction

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit inject);
        logic [47:0] exp = ref_token(idx, arg);
        logic [47:0] got = '0;
        bit hold_ok = 1;
        bit quiet = 1;
        int waitc = 0;
        @(negedge clk);
        start = 1; cmd_index = idx; cmd_arg = arg;
        @(negedge clk);
        start = 0; cmd_index = 6'($urandom); cmd_arg = $urandom;
        check(busy === 1'b1, "R6 busy after start", 64'(busy), 64'd1);
        if (inject) begin  // R7: second request during CRC phase
            @(negedge clk);
            start = 1; cmd_index = ~idx; cmd_arg = ~arg;
            @(negedge clk);
            start = 0;
        end
        while (cmd_out === 1'b1 && waitc < 200) begin
            if (done !== 1'b0) quiet = 0;
            @(negedge clk); waitc++;
        end
        check(quiet, "R5 R6 no early done, line high before token", 64'(waitc), 64'd0);
        for (int b = 0; b < 48; b++) begin
            got[47-b] = cmd_out;
            for (int k = 1; k < DIV; k++) begin
                @(negedge clk);
                if (cmd_out !== got[47-b] || done !== 1'b0) hold_ok = 0;
            end
            @(negedge clk);
        end
        check(got === exp, inject ? "R4 R7 serial token" : "R4 serial token", 64'(got), 64'(exp));
        check(hold_ok, "R4 bit held DIV cycles", 64'(hold_ok), 64'd1);
        check(done === 1'b1 && busy === 1'b0, "R8 done with busy low", {62'd0, done, busy}, 64'd2);
        @(negedge clk);
        check(done === 1'b0 && cmd_out === 1'b1, "R8 R5 done single, line idle", {62'd0, done, cmd_out}, 64'd1);
        check(word_hi === exp[47:32], "R1 R2 word_hi", 64'(word_hi), 64'(exp[47:32]));
        check(word_mid === exp[31:16], "R2 word_mid", 64'(word_mid), 64'(exp[31:16]));
        check(word_lo === exp[15:0], "R3 word_lo", 64'(word_lo), 64'(exp[15:0]));
        if (inject) begin
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (busy !== 1'b0 || cmd_out !== 1'b1) quiet = 0;
            end
            check(quiet, "R7 no second transfer", 64'(busy), 64'd0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1D));
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R9 reset busy/done", {62'd0, busy, done}, 64'd0);
        check(cmd_out === 1'b1, "R9 R5 reset line high", 64'(cmd_out), 64'd1);
        check({word_hi, word_mid, word_lo} === 48'd0, "R9 reset words", 64'({word_hi, word_mid, word_lo}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(cmd_out === 1'b1 && busy === 1'b0, "R5 idle after reset", {62'd0, cmd_out, busy}, 64'd2);

        run_cmd(6'd0, 32'h0, 0);
        check(word_lo[7:0] === 8'h95, "R3 known CRC byte index 0", 64'(word_lo[7:0]), 64'h95);
        check(word_hi === 16'h4000, "R1 framing index 0", 64'(word_hi), 64'h4000);
        run_cmd(6'd8, 32'h0000_01AA, 0);
        check(word_lo[7:0] === 8'h87, "R3 known CRC byte index 8", 64'(word_lo[7:0]), 64'h87);
        run_cmd(6'h3F, 32'hFFFF_FFFF, 0);
        check(word_hi[15:8] === 8'h7F, "R1 framing all-ones index", 64'(word_hi[15:8]), 64'h7F);
        run_cmd(6'h11, 32'h8000_0001, 1);

        for (int n = 0; n < 24; n++)
            run_cmd(6'($urandom), $urandom, (n % 4) == 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R6 watchdog expired actual=busy expected=idle");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule